// File: doc/BRIEF.md
# Binary64 Compare, Min/Max and Sign-Injection Unit

This unit carries out the non-arithmetic two-operand operations of a floating-point pipeline on raw IEEE 754 binary64 bit patterns. These are minimum, maximum, equality, less-than, less-or-equal, and three ways of building a sign bit for one operand from the signs of both. Comparison answers come back as a single bit, zero-extended to the full 64-bit result. An invalid-operation flag reports NaN misuse under the usual quiet and ordered compare rules.

The caller presents both operands, a 4-bit operation code and a one-cycle `in_valid` strobe. The result and flag are computed combinationally and captured in output registers on the same clock edge. In the next cycle they appear together with `out_valid`. A small two-state controller drives `out_valid`. `ST_IDLE` moves to `ST_EMIT` on a strobe. `ST_EMIT` stays in `ST_EMIT` when another strobe arrives back to back, and returns to `ST_IDLE` when no strobe arrives. Subnormals are used as they are, with no flushing.

Top module: `fp64_cmpsel_unit`

## Requirements
- R1: The result, the flag and `out_valid` update one cycle after a cycle in which `in_valid` is high, and `out_valid` is high only in that cycle. With no strobe, the result and flag hold their previous values.
- R2: `op_sel` is encoded as 0 = min, 1 = max, 2 = equal, 3 = less-than, 4 = less-or-equal, 5 = sign copy, 6 = inverted sign copy and 7 = sign xor. Codes 8 to 15 give result 0 and flag 0.
- R3: An operand is NaN when bits 62:52 are all ones and bits 51:0 are not zero. A NaN is signaling when bit 51 is 0 and quiet when bit 51 is 1. An infinity is not a NaN.
- R4: For min and max, when exactly one operand is NaN, the result is the other operand, bit for bit.
- R5: For min and max, when both operands are NaN, the result is 0x7FF8000000000000.
- R6: For min and max, the flag is 1 only when at least one operand is a signaling NaN.
- R7: For min and max with two zero operands, min returns -0 if either operand is -0, and max returns +0 if either operand is +0.
- R8: Non-NaN values are ordered by sign and magnitude, and +0 equals -0. Compare results occupy bit 0, with bits 63:1 zero.
- R9: Equal returns 0 when any operand is NaN, and raises the flag only for a signaling NaN.
- R10: Less-than and less-or-equal return 0 and raise the flag when any operand is NaN, quiet or signaling.
- R11: Sign injection takes bits 62:0 from operand A. Bit 63 is B's sign (code 5), the inverse of B's sign (code 6) or A's sign XOR B's sign (code 7).
- R12: Sign injection never raises the flag and passes NaN payloads through unchanged.
- R13: During and just after reset, `out_valid`, the result and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 64 | Operand A, binary64 bits |
| opnd_b | input | 64 | Operand B, binary64 bits |
| out_valid | output | 1 | Result valid, one cycle per strobe |
| result | output | 64 | Selected value or zero-extended compare bit |
| invalid_flag | output | 1 | Invalid-operation exception |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe-to-valid timing, and that the outputs hold without a strobe;
- the zero upper bits of compare results;
- the canonical NaN when min or max sees two NaNs;
- the flag rules of equal versus the ordered compares, and the silence of sign injection;
- the zero output of reserved codes.

The actual ordering choices need the bench's scenarios to show them. These are which operand min and max pick, negative-versus-negative magnitude order, signed-zero tie breaking, infinities against finite values, and NaN payload pass-through.

// File: rtl/fp64_cmp_pkg.sv
package fp64_cmp_pkg;

    // Operation codes carried on op_sel
    typedef enum logic [3:0] {
        OP_MIN   = 4'd0,
        OP_MAX   = 4'd1,
        OP_EQ    = 4'd2,
        OP_LT    = 4'd3,
        OP_LE    = 4'd4,
        OP_SGNJ  = 4'd5,
        OP_SGNJN = 4'd6,
        OP_SGNJX = 4'd7
    } cmp_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

    // Per-operand classification bits
    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } opnd_info_t;

endpackage

// File: rtl/fp64_operand_decode.sv
module fp64_operand_decode
    import fp64_cmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] value,
    output opnd_info_t            info
);
    localparam int FP_W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = value[FP_W-2 -: EXP_W];
    assign frac_f = value[FRAC_W-1:0];

    always_comb begin
        info.sign    = value[FP_W-1];
        info.is_zero = (value[FP_W-2:0] == '0);
        info.is_nan  = (&exp_f) && (|frac_f);
        // the top fraction bit separates quiet from signaling
        info.is_snan = (&exp_f) && (|frac_f) && !frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/fp64_order_compare.sv
module fp64_order_compare
    import fp64_cmp_pkg::*;
#(
    parameter int FP_W = 64
) (
    input  logic [FP_W-1:0] val_a,
    input  logic [FP_W-1:0] val_b,
    input  opnd_info_t      info_a,
    input  opnd_info_t      info_b,
    output logic            a_lt_b,
    output logic            b_lt_a,
    output logic            a_eq_b
);
    logic both_zero;
    logic mag_lt;
    logic mag_gt;

    always_comb begin
        both_zero = info_a.is_zero && info_b.is_zero;
        mag_lt    = val_a[FP_W-2:0] < val_b[FP_W-2:0];
        mag_gt    = val_b[FP_W-2:0] < val_a[FP_W-2:0];
        // sign-magnitude order: negatives reverse magnitude order
        a_lt_b = !both_zero &&
                 (( info_a.sign && !info_b.sign) ||
                  (!info_a.sign && !info_b.sign && mag_lt) ||
                  ( info_a.sign &&  info_b.sign && mag_gt));
        b_lt_a = !both_zero &&
                 (( info_b.sign && !info_a.sign) ||
                  (!info_a.sign && !info_b.sign && mag_gt) ||
                  ( info_a.sign &&  info_b.sign && mag_lt));
        a_eq_b = both_zero || (val_a == val_b);
    end
endmodule

// File: rtl/fp64_cmpsel_core.sv
module fp64_cmpsel_core
    import fp64_cmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [3:0]            op_code,
    input  logic [EXP_W+FRAC_W:0] val_a,
    input  logic [EXP_W+FRAC_W:0] val_b,
    input  opnd_info_t            info_a,
    input  opnd_info_t            info_b,
    input  logic                  a_lt_b,
    input  logic                  b_lt_a,
    input  logic                  a_eq_b,
    output logic [EXP_W+FRAC_W:0] res,
    output logic                  flag
);
    localparam int FP_W = 1 + EXP_W + FRAC_W;
    localparam logic [FP_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic any_nan;
    logic any_snan;

    always_comb begin
        any_nan  = info_a.is_nan  || info_b.is_nan;
        any_snan = info_a.is_snan || info_b.is_snan;
        res  = '0;
        flag = 1'b0;
        case (op_code)
            OP_MIN: begin
                flag = any_snan;
                if (info_a.is_nan && info_b.is_nan) res = CANON_NAN;
                else if (info_a.is_nan)             res = val_b;
                else if (info_b.is_nan)             res = val_a;
                else if (a_lt_b)                    res = val_a;
                else if (b_lt_a)                    res = val_b;
                else                                res = info_a.sign ? val_a : val_b;
            end
            OP_MAX: begin
                flag = any_snan;
                if (info_a.is_nan && info_b.is_nan) res = CANON_NAN;
                else if (info_a.is_nan)             res = val_b;
                else if (info_b.is_nan)             res = val_a;
                else if (a_lt_b)                    res = val_b;
                else if (b_lt_a)                    res = val_a;
                else                                res = info_a.sign ? val_b : val_a;
            end
            OP_EQ: begin
                flag   = any_snan;
                res[0] = !any_nan && a_eq_b;
            end
            OP_LT: begin
                flag   = any_nan;
                res[0] = !any_nan && a_lt_b;
            end
            OP_LE: begin
                flag   = any_nan;
                res[0] = !any_nan && (a_lt_b || a_eq_b);
            end
            OP_SGNJ:  res = {info_b.sign, val_a[FP_W-2:0]};
            OP_SGNJN: res = {!info_b.sign, val_a[FP_W-2:0]};
            OP_SGNJX: res = {info_a.sign ^ info_b.sign, val_a[FP_W-2:0]};
            default: begin
                res  = '0;
                flag = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fp64_cmpsel_unit.sv
module fp64_cmpsel_unit
    import fp64_cmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [3:0]            op_sel,
    input  logic [EXP_W+FRAC_W:0] opnd_a,
    input  logic [EXP_W+FRAC_W:0] opnd_b,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] result,
    output logic                  invalid_flag
);
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int N_OPND = 2;

    logic [FP_W-1:0] opnd_vec  [N_OPND];
    opnd_info_t      info_vec  [N_OPND];
    logic            a_lt_b, b_lt_a, a_eq_b;
    logic [FP_W-1:0] comb_res;
    logic            comb_flag;

    emit_state_e     state_q, state_d;
    logic [FP_W-1:0] result_q;
    logic            flag_q;

    assign opnd_vec[0] = opnd_a;
    assign opnd_vec[1] = opnd_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_decode
        fp64_operand_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) dec_i (
            .value (opnd_vec[g]),
            .info  (info_vec[g])
        );
    end

    fp64_order_compare #(.FP_W(FP_W)) cmp_i (
        .val_a  (opnd_a),
        .val_b  (opnd_b),
        .info_a (info_vec[0]),
        .info_b (info_vec[1]),
        .a_lt_b (a_lt_b),
        .b_lt_a (b_lt_a),
        .a_eq_b (a_eq_b)
    );

    fp64_cmpsel_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) core_i (
        .op_code (op_sel),
        .val_a   (opnd_a),
        .val_b   (opnd_b),
        .info_a  (info_vec[0]),
        .info_b  (info_vec[1]),
        .a_lt_b  (a_lt_b),
        .b_lt_a  (b_lt_a),
        .a_eq_b  (a_eq_b),
        .res     (comb_res),
        .flag    (comb_flag)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers: load only on a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            flag_q   <= 1'b0;
        end else if (in_valid) begin
            result_q <= comb_res;
            flag_q   <= comb_flag;
        end
    end

    assign out_valid    = (state_q == ST_EMIT);
    assign result       = result_q;
    assign invalid_flag = flag_q;
endmodule

// File: rtl/fp64_cmpsel_checker.sv
module fp64_cmpsel_checker #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [3:0]            op_sel,
    input logic [EXP_W+FRAC_W:0] opnd_a,
    input logic [EXP_W+FRAC_W:0] opnd_b,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  invalid_flag
);
    localparam int FP_W = 1 + EXP_W + FRAC_W;
    localparam logic [FP_W-1:0] QNAN_C =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic nan_a, nan_b, snan_a, snan_b, is_cmp, is_ord, is_mm, is_sgn;
    assign nan_a  = (&opnd_a[FP_W-2 -: EXP_W]) && (|opnd_a[FRAC_W-1:0]);
    assign nan_b  = (&opnd_b[FP_W-2 -: EXP_W]) && (|opnd_b[FRAC_W-1:0]);
    assign snan_a = nan_a && !opnd_a[FRAC_W-1];
    assign snan_b = nan_b && !opnd_b[FRAC_W-1];
    assign is_mm  = (op_sel == 4'd0) || (op_sel == 4'd1);
    assign is_ord = (op_sel == 4'd3) || (op_sel == 4'd4);
    assign is_cmp = (op_sel == 4'd2) || is_ord;
    assign is_sgn = (op_sel >= 4'd5) && (op_sel <= 4'd7);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(invalid_flag)));
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 4'd8) |=> (result == '0 && !invalid_flag));
    a_r5_both_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_mm && nan_a && nan_b) |=> (result == QNAN_C));
    a_r8_cmp_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_cmp) |=> (result[FP_W-1:1] == '0));
    a_r9_eq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd2 && !snan_a && !snan_b) |=> !invalid_flag);
    a_r10_ord_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_ord && (nan_a || nan_b)) |=> (invalid_flag && result == '0));
    a_r11_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sgn) |=> (result[FP_W-2:0] == $past(opnd_a[FP_W-2:0])));
    a_r12_sgn_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sgn) |=> !invalid_flag);
endmodule

bind fp64_cmpsel_unit fp64_cmpsel_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_sel       (op_sel),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .out_valid    (out_valid),
    .result       (result),
    .invalid_flag (invalid_flag)
);

// File: tb/fp64_cmpsel_unit_tb_top.sv
module fp64_cmpsel_unit_tb_top;
    localparam logic [63:0] P1   = 64'h3FF0000000000000;
    localparam logic [63:0] M1   = 64'hBFF0000000000000;
    localparam logic [63:0] P2   = 64'h4000000000000000;
    localparam logic [63:0] M2   = 64'hC000000000000000;
    localparam logic [63:0] PZ   = 64'h0000000000000000;
    localparam logic [63:0] NZ   = 64'h8000000000000000;
    localparam logic [63:0] QN   = 64'h7FF8000000000000;
    localparam logic [63:0] QNP  = 64'h7FF8000000000123;
    localparam logic [63:0] NQN  = 64'hFFF8000000000005;
    localparam logic [63:0] SN   = 64'h7FF0000000000001;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;
    localparam logic [63:0] ONE  = 64'd1;

    typedef struct packed {
        logic [3:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        fl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{4'd0, P1, P2, P1, 1'b0, 8'd8},     // R8 min positives
        '{4'd0, M1, P1, M1, 1'b0, 8'd8},     // R8 mixed signs
        '{4'd0, M2, M1, M2, 1'b0, 8'd8},     // R8 both negative
        '{4'd1, M2, M1, M1, 1'b0, 8'd8},
        '{4'd1, P1, P2, P2, 1'b0, 8'd2},     // R2 max code
        '{4'd0, QNP, P2, P2, 1'b0, 8'd4},    // R4
        '{4'd1, P1, QNP, P1, 1'b0, 8'd4},
        '{4'd0, SN, P1, P1, 1'b1, 8'd6},     // R6 signaling raises
        '{4'd1, QNP, NQN, QN, 1'b0, 8'd5},   // R5 quiet pair, no flag
        '{4'd0, SN, QNP, QN, 1'b1, 8'd5},
        '{4'd0, PZ, NZ, NZ, 1'b0, 8'd7},     // R7
        '{4'd0, NZ, PZ, NZ, 1'b0, 8'd7},
        '{4'd1, NZ, PZ, PZ, 1'b0, 8'd7},
        '{4'd1, PZ, NZ, PZ, 1'b0, 8'd7},
        '{4'd2, P1, P1, ONE, 1'b0, 8'd8},
        '{4'd2, PZ, NZ, ONE, 1'b0, 8'd8},
        '{4'd2, P1, P2, PZ, 1'b0, 8'd8},
        '{4'd2, QNP, QNP, PZ, 1'b0, 8'd9},   // R9 quiet NaN no flag
        '{4'd2, SN, P1, PZ, 1'b1, 8'd9},
        '{4'd3, M1, P1, ONE, 1'b0, 8'd8},
        '{4'd3, P2, P1, PZ, 1'b0, 8'd8},
        '{4'd3, M2, M1, ONE, 1'b0, 8'd8},
        '{4'd3, NZ, PZ, PZ, 1'b0, 8'd8},
        '{4'd4, NZ, PZ, ONE, 1'b0, 8'd8},
        '{4'd4, P1, P1, ONE, 1'b0, 8'd8},
        '{4'd4, P2, P1, PZ, 1'b0, 8'd8},
        '{4'd3, QNP, P1, PZ, 1'b1, 8'd10},   // R10
        '{4'd4, P1, QNP, PZ, 1'b1, 8'd10},
        '{4'd3, NINF, M2, ONE, 1'b0, 8'd3},  // R3 infinity is ordered
        '{4'd5, P1, M2, M1, 1'b0, 8'd11},    // R11
        '{4'd6, P1, M2, P1, 1'b0, 8'd11},
        '{4'd6, P1, P2, M1, 1'b0, 8'd11},
        '{4'd7, M1, M2, P1, 1'b0, 8'd11},
        '{4'd7, M1, P2, M1, 1'b0, 8'd11},
        '{4'd5, SN, NZ, 64'hFFF0000000000001, 1'b0, 8'd12}, // R12
        '{4'd8, P1, P2, PZ, 1'b0, 8'd2},     // R2 reserved
        '{4'd15, SN, SN, PZ, 1'b0, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid_flag;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    fp64_cmpsel_unit dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_sel (op_sel),
        .opnd_a (opnd_a), .opnd_b (opnd_b), .out_valid (out_valid),
        .result (result), .invalid_flag (invalid_flag)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R13 out_valid in reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 result after reset", result, 64'd0);
        check("R13 flag after reset", {63'd0, invalid_flag}, 64'd0);
        check("R13 out_valid after reset", {63'd0, out_valid}, 64'd0);

        // table walk: strobe one cycle, sample at the following negedge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            op_sel   = VECS[i].op;
            opnd_a   = VECS[i].a;
            opnd_b   = VECS[i].b;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].exp);
            check($sformatf("R%0d vec %0d flag", VECS[i].req, i),
                  {63'd0, invalid_flag}, {63'd0, VECS[i].fl});
            check($sformatf("R1 vec %0d out_valid", i), {63'd0, out_valid}, 64'd1);
        end

        // R1: pulse lasts one cycle and outputs hold without strobe
        held = result;
        opnd_a = P2;
        op_sel = 4'd1;
        @(negedge clk);
        check("R1 out_valid pulse ends", {63'd0, out_valid}, 64'd0);
        repeat (3) @(negedge clk);
        check("R1 result held", result, held);

        // R1: back-to-back strobes keep out_valid high with fresh results
        in_valid = 1'b1; op_sel = 4'd0; opnd_a = M2; opnd_b = P1;
        @(negedge clk);
        op_sel = 4'd1;
        check("R1 first of pair", result, M2);
        check("R1 first valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 second of pair", result, P1);
        check("R1 second valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        check("R1 pair ends", {63'd0, out_valid}, 64'd0);

        // R12: quiet NaN payload survives sign xor
        in_valid = 1'b1; op_sel = 4'd7; opnd_a = QNP; opnd_b = PZ;
        @(negedge clk);
        in_valid = 1'b0;
        check("R12 payload kept", result, QNP);
        check("R12 no flag", {63'd0, invalid_flag}, 64'd0);

        // R13: reset mid-run clears registered outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R13 reset clears result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule